// File: doc/BRIEF.md
# Nonvolatile Byte Write Sequencer

This block is the register front end between a CPU bus and a 2048-byte nonvolatile memory array. Software reaches three registers through one write port: an address register, a data register and a control register that holds an arming bit, a write-go bit and a read-go bit. A write to the array is accepted only after a two-step handshake. Software first sets the arming bit with the go bit clear, then sets the go bit within a short window. A write is also refused while an external flash-programming busy input is high.

Once a write is accepted, the go bit stays high and acts as the busy flag. It stays high until a dedicated counter has seen the programming time in timing-oscillator ticks. The ticks arrive as a one-cycle enable in the system clock domain. While busy, the block stalls the CPU for two cycles, holds the array address fixed and refuses reads. When the time has elapsed, the block commits the byte to the array and pulses a one-cycle ready output that can serve as an interrupt request. Reads run only when the block is idle: the addressed byte lands in the data register one clock after the read-go bit is set.

Top module: `nvm_wr_seq`

## Requirements
- R1: A control write (`cpu_sel`=2) with bit 0 = 1 and bit 1 = 0 arms the block, so `stat_armed` reads 1 after that edge. A control write with bits 0 and 1 both set does not arm it.
- R2: A control write with bit 1 = 1 starts a write if the arming edge was 1 to 4 clock edges earlier. Once 4 edges have passed, `stat_armed` clears and a go write has no effect.
- R3: `stat_busy` rises at the edge that accepts a go write. It falls at the edge that takes the PROG_TICKS-th `osc_tick` after the start.
- R4: The programming counter advances only on clock edges where `osc_tick` is high. Any number of cycles without a tick leaves `stat_busy` set.
- R5: `cpu_stall` is high for exactly the two cycles that follow the edge that starts a write.
- R6: A control write with bit 2 = 1 while `stat_busy` is set is ignored. `stat_rd` stays 0 and `data_out` keeps its value.
- R7: An address write (`cpu_sel`=0) while `stat_busy` is set leaves `mem_addr` unchanged.
- R8: No write starts while `flash_busy` is high, even when the block is armed.
- R9: A control write with bit 2 = 1 while idle sets `stat_rd` for one cycle. At the next edge `data_out` takes `mem_rdata`, and `stat_rd` clears.
- R10: An address write stores only the low 11 bits of `cpu_wdata`.
- R11: The edge that ends a write raises `wr_ready` and `mem_we` for exactly one cycle. The array stores the data register value captured at start, not later data writes.
- R12: While `rst` is high, `stat_busy`, `stat_armed`, `stat_rd`, `cpu_stall`, `wr_ready`, `mem_we`, `data_out` and `mem_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe from the CPU |
| cpu_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| cpu_wdata | input | 16 | Register write data |
| flash_busy | input | 1 | Flash programming in progress; blocks write starts |
| osc_tick | input | 1 | One-cycle timing oscillator enable |
| mem_rdata | input | 8 | Array read data for the current address |
| mem_addr | output | 11 | Array address (address register) |
| mem_wdata | output | 8 | Byte being programmed |
| mem_we | output | 1 | One-cycle array write commit |
| data_out | output | 8 | Data register contents |
| stat_busy | output | 1 | Write-go bit / write in progress |
| stat_armed | output | 1 | Arming window open |
| stat_rd | output | 1 | Read-go bit |
| cpu_stall | output | 1 | CPU hold-off after a write start |
| wr_ready | output | 1 | One-cycle write-complete pulse |

## Verification
Each register write takes effect at the edge that samples it. Status, address and stall values are therefore due in the cycle right after that edge. Read data is due one cycle later, and the stall drops two cycles after a start. Completion is due at the edge that takes the last tick, and the array commit one edge after that. The driver records each expected value together with the exact clock index at which it becomes due, and the monitor compares it a fixed fraction of a period after that edge.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_ARM_BIT = 0;
  localparam int CTL_GO_BIT  = 1;
  localparam int CTL_RD_BIT  = 2;

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_set,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (arm_set) begin
      cnt_q <= CW'(WIN);
    end else if (consume) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign armed = (cnt_q != '0);

  // R2: the window only shrinks unless re-armed or consumed
  a_r2_window_shrinks: assert property (@(posedge clk) disable iff (rst)
    (armed && !arm_set && !consume) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R2: a fresh arm always opens the window on the next cycle
  a_r2_arm_opens: assert property (@(posedge clk) disable iff (rst)
    arm_set |=> armed);

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int TICKS = 27072
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        cnt_q  <= CW'(TICKS);
        busy_q <= 1'b1;
      end else if (busy_q && tick) begin
        if (cnt_q == CW'(1)) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R4: without a tick the count and the busy flag hold
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> (busy_q && $stable(cnt_q)));

  // R3: completion is reported only once busy has dropped
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int STALL_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic stall
);
  localparam int CW = $clog2(STALL_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(STALL_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign stall = (cnt_q != '0);

  // R5: a start always produces a stall in the following cycle
  a_r5_start_stalls: assert property (@(posedge clk) disable iff (rst)
    start |=> stall);

endmodule

// File: rtl/nvm_wr_seq.sv
module nvm_wr_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int BUS_W      = 16,
  parameter int ARM_WIN    = 4,
  parameter int PROG_TICKS = 27072,
  parameter int STALL_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_sel,
  input  logic [BUS_W-1:0]  cpu_wdata,
  input  logic              flash_busy,
  input  logic              osc_tick,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] data_out,
  output logic              stat_busy,
  output logic              stat_armed,
  output logic              stat_rd,
  output logic              cpu_stall,
  output logic              wr_ready
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] wlat_q;
  logic              rd_q;

  logic ctl_wr, addr_wr, data_wr;
  logic arm_set, go_req, start, rd_req;
  logic armed, busy, done;

  always_comb begin
    ctl_wr  = cpu_wr && (reg_sel_e'(cpu_sel) == SEL_CTL);
    addr_wr = cpu_wr && (reg_sel_e'(cpu_sel) == SEL_ADDR);
    data_wr = cpu_wr && (reg_sel_e'(cpu_sel) == SEL_DATA);
    arm_set = ctl_wr && cpu_wdata[CTL_ARM_BIT] && !cpu_wdata[CTL_GO_BIT];
    go_req  = ctl_wr && cpu_wdata[CTL_GO_BIT];
    start   = go_req && armed && !busy && !flash_busy;
    rd_req  = ctl_wr && cpu_wdata[CTL_RD_BIT] && !busy && !start;
  end

  nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .arm_set (arm_set),
    .consume (start),
    .armed   (armed)
  );

  nvm_prog_timer #(.TICKS(PROG_TICKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .tick  (osc_tick),
    .busy  (busy),
    .done  (done)
  );

  nvm_stall_gen #(.STALL_CYC(STALL_CYC)) u_stall (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stall (cpu_stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      wlat_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (addr_wr && !busy) begin
        addr_q <= cpu_wdata[ADDR_W-1:0];
      end
      if (rd_q) begin
        data_q <= mem_rdata;
      end else if (data_wr) begin
        data_q <= cpu_wdata[DATA_W-1:0];
      end
      if (start) begin
        wlat_q <= data_q;
      end
      rd_q <= rd_req;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_wdata  = wlat_q;
  assign mem_we     = done;
  assign wr_ready   = done;
  assign data_out   = data_q;
  assign stat_busy  = busy;
  assign stat_armed = armed;
  assign stat_rd    = rd_q;

  // R7: address register frozen for the whole write
  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    stat_busy |=> $stable(mem_addr));

  // R6: no read may be pending while a write runs
  a_r6_no_read_busy: assert property (@(posedge clk) disable iff (rst)
    stat_busy |-> !stat_rd);

  // R9: read-go bit clears itself after one cycle
  a_r9_rd_selfclear: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !stat_rd);

  // R8: flash activity blocks a start
  a_r8_flash_blocks: assert property (@(posedge clk) disable iff (rst)
    (flash_busy && !stat_busy) |=> !stat_busy);

  // R11: completion pulse lasts a single cycle
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_ready |=> !wr_ready);

  // R11: every end of busy comes with the ready pulse
  a_r11_ready_on_end: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_busy) |-> wr_ready);

  // R5: the CPU is held off as soon as busy appears
  a_r5_stall_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_busy) |-> cpu_stall);

endmodule

// File: tb/nvm_wr_seq_test.sv
`timescale 1ns/1ps
module nvm_wr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 6;

  localparam int S_BUSY = 0, S_ARMED = 1, S_RD = 2, S_STALL = 3,
                 S_READY = 4, S_MEMWE = 5, S_DATA = 6, S_ADDR = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_sel = 2'd3;
  logic [15:0] cpu_wdata = '0;
  logic        flash_busy = 1'b0;
  logic        osc_tick = 1'b0;
  logic [7:0]  mem_rdata;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  data_out;
  logic        stat_busy, stat_armed, stat_rd, cpu_stall, wr_ready;

  logic [7:0] arr [2048];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int          due;
    int          sig;
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_wr_seq #(.PROG_TICKS(TICKS)) uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .flash_busy(flash_busy), .osc_tick(osc_tick),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .data_out(data_out), .stat_busy(stat_busy),
    .stat_armed(stat_armed), .stat_rd(stat_rd), .cpu_stall(cpu_stall),
    .wr_ready(wr_ready)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  initial begin
    for (int i = 0; i < 2048; i++) arr[i] = init_val(i);
  end
  assign mem_rdata = arr[mem_addr];
  always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] probe(int s);
    case (s)
      S_BUSY:  return 16'(stat_busy);
      S_ARMED: return 16'(stat_armed);
      S_RD:    return 16'(stat_rd);
      S_STALL: return 16'(cpu_stall);
      S_READY: return 16'(wr_ready);
      S_MEMWE: return 16'(mem_we);
      S_DATA:  return 16'(data_out);
      default: return 16'(mem_addr);
    endcase
  endfunction

  // monitor: compares every expectation due at this edge
  always begin
    @(posedge clk);
    #3;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (probe(q[i].sig) !== q[i].val) begin
          fails++;
          $display("FAIL %s sig%0d actual %h expected %h at cycle %0d",
                   q[i].req, q[i].sig, probe(q[i].sig), q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(int k, int s, logic [15:0] v, string r);
    exp_t e;
    e.due = cyc + k; e.sig = s; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] v);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = v;
    @(posedge clk); #1;
    cpu_wr = 1'b0; cpu_sel = 2'd3;
  endtask

  task automatic idle(int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic tick();
    @(negedge clk); osc_tick = 1'b1;
    @(posedge clk); #1; osc_tick = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R12 reset state
    idle(2);
    expect_at(0, S_BUSY, 0, "R12"); expect_at(0, S_ARMED, 0, "R12");
    expect_at(0, S_RD, 0, "R12");   expect_at(0, S_STALL, 0, "R12");
    expect_at(0, S_READY, 0, "R12"); expect_at(0, S_MEMWE, 0, "R12");
    expect_at(0, S_DATA, 0, "R12"); expect_at(0, S_ADDR, 0, "R12");
    idle(1);
    rst = 1'b0;
    idle(1);

    // R10 address masking
    wr(2'd0, 16'hFAB5);
    expect_at(0, S_ADDR, 16'h02B5, "R10");
    // R9 idle read
    wr(2'd2, 16'h0004);
    expect_at(0, S_RD, 1, "R9");
    expect_at(1, S_RD, 0, "R9");
    expect_at(1, S_DATA, 16'(init_val(16'h2B5)), "R9");
    idle(2);

    // R1 arm, R2 window expiry
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h005A);
    wr(2'd2, 16'h0001);
    expect_at(0, S_ARMED, 1, "R1");
    expect_at(3, S_ARMED, 1, "R2");
    expect_at(4, S_ARMED, 0, "R2");
    idle(4);
    wr(2'd2, 16'h0002);
    expect_at(0, S_BUSY, 0, "R2");
    // R1 arm with go set does not arm
    wr(2'd2, 16'h0003);
    expect_at(0, S_ARMED, 0, "R1");
    expect_at(0, S_BUSY, 0, "R1");
    idle(1);

    // R2 accept at the last edge of the window, R5 stall
    wr(2'd2, 16'h0001);
    idle(3);
    wr(2'd2, 16'h0002);
    expect_at(0, S_BUSY, 1, "R2");
    expect_at(0, S_ARMED, 0, "R2");
    expect_at(0, S_STALL, 1, "R5");
    expect_at(1, S_STALL, 1, "R5");
    expect_at(2, S_STALL, 0, "R5");
    // R4 no ticks, still busy
    idle(5);
    expect_at(0, S_BUSY, 1, "R4");
    // R7 address frozen
    wr(2'd0, 16'h0123);
    expect_at(0, S_ADDR, 16'h0010, "R7");
    // R6 read ignored while busy
    wr(2'd2, 16'h0004);
    expect_at(0, S_RD, 0, "R6");
    expect_at(1, S_DATA, 16'h005A, "R6");
    idle(1);
    wr(2'd1, 16'h0077);
    expect_at(0, S_BUSY, 1, "R4");
    // R3 tick count
    for (int t = 1; t < TICKS; t++) begin
      tick();
      expect_at(0, S_BUSY, 1, "R3");
    end
    tick();
    expect_at(0, S_BUSY, 0, "R3");
    expect_at(0, S_READY, 1, "R11");
    expect_at(0, S_MEMWE, 1, "R11");
    expect_at(1, S_READY, 0, "R11");
    expect_at(1, S_MEMWE, 0, "R11");
    idle(1);
    // R11 array holds the byte latched at start
    wr(2'd2, 16'h0004);
    expect_at(1, S_DATA, 16'h005A, "R11");
    idle(2);

    // R8 flash busy blocks start
    wr(2'd1, 16'h0077);
    flash_busy = 1'b1;
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0002);
    expect_at(0, S_BUSY, 0, "R8");
    expect_at(0, S_ARMED, 1, "R8");
    flash_busy = 1'b0;
    wr(2'd2, 16'h0002);
    expect_at(0, S_BUSY, 1, "R8");
    for (int t = 1; t < TICKS; t++) begin
      tick();
      idle(2);
      expect_at(0, S_BUSY, 1, "R4");
    end
    tick();
    expect_at(0, S_BUSY, 0, "R3");
    expect_at(0, S_READY, 1, "R11");
    idle(1);
    wr(2'd2, 16'h0004);
    expect_at(1, S_DATA, 16'h0077, "R11");
    idle(1);
    // R7 address accepted once idle
    wr(2'd0, 16'hFFFF);
    expect_at(0, S_ADDR, 16'h07FF, "R7");
    idle(4);

    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL pending expectations %0d expected 0", q.size());
    end
    summary();
    $finish;
  end

endmodule